// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a pipelined synchronous SRAM. It accepts one operation on every enabled clock, read or write, in any order, with no idle cycles between them. Address, write enable, byte selects, chip enables and clock enable are all registered on the rising edge. The shared data bus is split into a data input, a registered data output and a drive-enable flag.

For every operation, the data moves on the bus two enabled clocks after its address. Read data is loaded into the output register one enabled edge after the address edge and is held through the next cycle. Write data is sampled on the second enabled edge after the address edge. Because reads and writes keep the same spacing, a write can follow a read, or a read can follow a write, without a turnaround slot.

A read can reach an address whose write is still in the pipeline. In that case the read returns the new bytes merged with the stored word. Deasserting the clock enable freezes the whole pipeline. The output enable gates the bus drive without waiting for a clock.

Top module: `pipe_sram`

## Requirements
- R1: While reset (rstN low) is applied, dOutEn is 0 and dOut is 0.
- R2: A selected read whose address is sampled at enabled edge k places the stored word on dOut after edge k+1. With oeN low, dOutEn is 1 until enabled edge k+2.
- R3: A selected write whose address is sampled at enabled edge k stores the dIn value sampled at enabled edge k+2.
- R4: byteSelN is active low. Bit b gates bits 8b+7..8b of the word. With byteSelN = 4'hF a write cycle leaves the word unchanged.
- R5: Any mix of reads and writes, issued one per enabled clock, completes in issue order with no wait states.
- R6: A read issued on the clock right after a write to the same address returns that write's bytes, merged under its byte mask with the previously stored bytes.
- R7: An operation starts only when csN1 is 0, cs2 is 1 and csN3 is 0. Any other combination is a deselect. A deselect stores nothing, and dOutEn is 0 in its data cycle.
- R8: During the data cycle of a write (between enabled edges k+1 and k+2), dOutEn is 0 whatever the level of oeN.
- R9: oeN = 1 forces dOutEn to 0 combinationally. Returning oeN to 0 restores the drive at once, without a clock edge.
- R10: While clkEn is 0, no pipeline stage, output register or array word changes. dOut and dOutEn hold their values, and a pending write waits for the next enabled edge to take its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEn | input | 1 | Clock enable, active high; 0 freezes the block |
| addr | input | ADDR_W | Word address |
| wrN | input | 1 | Write enable, active low (1 = read) |
| byteSelN | input | 4 | Byte-lane write selects, active low |
| csN1 | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| csN3 | input | 1 | Chip select, active low |
| oeN | input | 1 | Asynchronous output enable, active low |
| dIn | input | 32 | Write data from the bus |
| dOut | output | 32 | Registered read data |
| dOutEn | output | 1 | Bus drive enable for dOut |

## Verification
The timing rules are defined for an operation whose address is sampled at enabled edge k:
- Its data cycle is the one between enabled edges k+1 and k+2.
- Read data and the drive flag are due in that data cycle.
- Write data is taken at edge k+2.

The vector loop applies this rule directly. Inputs for cycle c are driven one time unit after an edge, and at that point the loop checks the result of the operation issued two cycles earlier. The loop also drives that operation's write data on dIn during cycle c.

In the directed tests, clock-enable stalls are placed between the address and data edges. The expected value in those tests follows enabled edges only, not clock periods. The oeN checks are made without any intervening clock.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  // strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic             rdLoad;   // load output register at this edge
    logic             fwd;      // pending write targets the read address
    logic             wrCommit; // store write data at this edge
    logic [LANES-1:0] laneEn;   // active-high lane mask of the pending write
  } strobe_t;
endpackage

// File: rtl/pipe_sram_ctrl.sv
module pipe_sram_ctrl
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrN,
  input  logic [LANES-1:0]  byteSelN,
  input  logic              csN1,
  input  logic              cs2,
  input  logic              csN3,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              driveRead
);
  typedef struct packed {
    logic              valid;
    logic              isWrite;
    logic [LANES-1:0]  lanes;
    logic [ADDR_W-1:0] addr;
  } stage_t;

  stage_t issue, addrStage, dataStage;

  always_comb begin
    issue.valid   = !csN1 && cs2 && !csN3;
    issue.isWrite = !wrN;
    issue.lanes   = ~byteSelN;
    issue.addr    = addr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrStage <= '0;
      dataStage <= '0;
    end else if (clkEn) begin
      addrStage <= issue;
      dataStage <= addrStage;
    end
  end

  always_comb begin
    stb.wrCommit = clkEn && dataStage.valid && dataStage.isWrite;
    stb.laneEn   = dataStage.lanes;
    stb.rdLoad   = clkEn && addrStage.valid && !addrStage.isWrite;
    stb.fwd      = dataStage.valid && dataStage.isWrite &&
                   (dataStage.addr == addrStage.addr);
  end

  assign rdAddr    = addrStage.addr;
  assign wrAddr    = dataStage.addr;
  assign driveRead = dataStage.valid && !dataStage.isWrite;
endmodule

// File: rtl/pipe_sram_dp.sv
module pipe_sram_dp
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              driveRead,
  input  logic              oeN,
  input  logic [WORD_W-1:0] dIn,
  output logic [WORD_W-1:0] dOut,
  output logic              dOutEn
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rdWord;
  logic [WORD_W-1:0] outReg;

  always_ff @(posedge clk) begin
    if (stb.wrCommit) begin
      for (int b = 0; b < LANES; b++) begin
        if (stb.laneEn[b]) mem[wrAddr][b*LANE_W +: LANE_W] <= dIn[b*LANE_W +: LANE_W];
      end
    end
  end

  // bypass: a write committing at this edge overrides stale lanes of the read
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign rdWord[g*LANE_W +: LANE_W] = (stb.fwd && stb.laneEn[g]) ?
        dIn[g*LANE_W +: LANE_W] : mem[rdAddr][g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           outReg <= '0;
    else if (stb.rdLoad) outReg <= rdWord;
  end

  assign dOut   = outReg;
  assign dOutEn = driveRead && !oeN;
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrN,
  input  logic [3:0]        byteSelN,
  input  logic              csN1,
  input  logic              cs2,
  input  logic              csN3,
  input  logic              oeN,
  input  logic [31:0]       dIn,
  output logic [31:0]       dOut,
  output logic              dOutEn
);
  strobe_t           stb;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic              driveRead;

  pipe_sram_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .addr(addr), .wrN(wrN),
    .byteSelN(byteSelN), .csN1(csN1), .cs2(cs2), .csN3(csN3),
    .stb(stb), .rdAddr(rdAddr), .wrAddr(wrAddr), .driveRead(driveRead)
  );

  pipe_sram_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .driveRead(driveRead), .oeN(oeN), .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn)
  );
endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk (
  input logic        clk,
  input logic        rstN,
  input logic        clkEn,
  input logic        wrN,
  input logic        csN1,
  input logic        cs2,
  input logic        csN3,
  input logic        oeN,
  input logic [31:0] dOut,
  input logic        dOutEn
);
  logic sel;
  assign sel = !csN1 && cs2 && !csN3;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |-> (!dOutEn && dOut == '0));

  assert_read_drive_R2: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && sel && wrN) ##1 clkEn |=> (dOutEn == !oeN));

  assert_deselect_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !sel) ##1 clkEn |=> !dOutEn);

  assert_write_no_drive_R8: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && sel && !wrN) ##1 clkEn |=> !dOutEn);

  assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !dOutEn);

  assert_freeze_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> ($stable(dOut) && $stable(dOutEn || oeN)));
endmodule

bind pipe_sram pipe_sram_chk chk_i (
  .clk(clk), .rstN(rstN), .clkEn(clkEn), .wrN(wrN), .csN1(csN1), .cs2(cs2),
  .csN3(csN3), .oeN(oeN), .dOut(dOut), .dOutEn(dOutEn)
);

// File: tb/pipe_sram_tb_top.sv
`timescale 1ns/1ps
module pipe_sram_tb_top;
  localparam int NV = 16;
  localparam logic [2:0] ACT = 3'b010;   // {csN1, cs2, csN3}
  localparam logic [2:0] DES = 3'b110;

  // {sel, write, laneEn[3:0], addr[7:0], data[31:0]}
  localparam logic [45:0] VEC [NV] = '{
    {1'b1, 1'b1, 4'hF, 8'h10, 32'h11112222},
    {1'b1, 1'b1, 4'hF, 8'h11, 32'h33334444},
    {1'b1, 1'b0, 4'h0, 8'h10, 32'h0},
    {1'b1, 1'b1, 4'h3, 8'h10, 32'hAAAABBBB},
    {1'b1, 1'b0, 4'h0, 8'h10, 32'h0},
    {1'b1, 1'b1, 4'hC, 8'h11, 32'h55556666},
    {1'b1, 1'b0, 4'h0, 8'h11, 32'h0},
    {1'b0, 1'b1, 4'hF, 8'h10, 32'hDEADBEEF},
    {1'b1, 1'b0, 4'h0, 8'h10, 32'h0},
    {1'b1, 1'b1, 4'h0, 8'h11, 32'hFFFFFFFF},
    {1'b1, 1'b0, 4'h0, 8'h11, 32'h0},
    {1'b1, 1'b1, 4'hF, 8'h12, 32'h0A0B0C0D},
    {1'b1, 1'b1, 4'h5, 8'h12, 32'hF0E0D0C0},
    {1'b1, 1'b0, 4'h0, 8'h12, 32'h0},
    {1'b1, 1'b0, 4'h0, 8'h11, 32'h0},
    {1'b1, 1'b0, 4'h0, 8'h10, 32'h0}
  };

  logic        clk = 0, rstN = 0, clkEn = 1, wrN = 1, oeN = 0;
  logic        csN1 = 1, cs2 = 1, csN3 = 0;
  logic [7:0]  addr = '0;
  logic [3:0]  byteSelN = 4'hF;
  logic [31:0] dIn = '0, dOut;
  logic        dOutEn;
  int          nVec = 0, nBad = 0;
  bit          done = 0;
  logic [31:0] model [256];

  always #2.5 clk = ~clk;

  pipe_sram #(.ADDR_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .addr(addr), .wrN(wrN),
    .byteSelN(byteSelN), .csN1(csN1), .cs2(cs2), .csN3(csN3), .oeN(oeN),
    .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic drive(input logic [2:0] cs, input logic wr, input logic [3:0] be, input logic [7:0] a);
    {csN1, cs2, csN3} = cs;
    wrN = !wr; byteSelN = ~be; addr = a;
  endtask

  task automatic writeWord(input logic [2:0] cs, input logic [3:0] be, input logic [7:0] a, input logic [31:0] d);
    drive(cs, 1'b1, be, a); tick();
    drive(DES, 1'b0, 4'h0, 8'h0); tick();
    dIn = d; tick();
    dIn = '0;
  endtask

  task automatic readBack(input logic [7:0] a, input logic [31:0] exp, input string tag);
    drive(ACT, 1'b0, 4'h0, a); tick();
    drive(DES, 1'b0, 4'h0, 8'h0); tick();
    chk({tag, " data"}, dOut, exp);
    chk({tag, " drive"}, {31'b0, dOutEn}, 32'd1);
  endtask

  initial begin
    #100000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 reset dOutEn", {31'b0, dOutEn}, 32'd0);
    chk("R1 reset dOut", dOut, 32'd0);
    repeat (2) @(posedge clk);
    #1 rstN = 1;

    // vector loop: cycle c drives op c and dIn for op c-2, checks op c-2
    for (int c = 0; c < NV + 2; c++) begin
      if (c >= 2) begin
        logic [45:0] op;
        op = VEC[c-2];
        if (op[45] && !op[44]) chk("R2 R5 R6 read data", dOut, model[op[39:32]]);
        chk("R2 R7 R8 drive", {31'b0, dOutEn}, {31'b0, op[45] && !op[44]});
        if (op[45] && op[44])
          for (int b = 0; b < 4; b++)
            if (op[40+b]) model[op[39:32]][b*8 +: 8] = op[b*8 +: 8];
      end
      if (c < NV) drive(VEC[c][45] ? ACT : DES, VEC[c][44], VEC[c][43:40], VEC[c][39:32]);
      else        drive(DES, 1'b0, 4'h0, 8'h0);
      dIn = (c >= 2 && VEC[c-2][44]) ? VEC[c-2][31:0] : 32'h0;
      tick();
    end

    // R3 R10: stall between address and data edges of a write
    drive(ACT, 1'b1, 4'hF, 8'h20); tick();
    drive(DES, 1'b0, 4'h0, 8'h0); tick();
    clkEn = 0; dIn = 32'h0BADBAD0;
    for (int i = 0; i < 3; i++) begin
      chk("R8 R10 stalled write no drive", {31'b0, dOutEn}, 32'd0);
      tick();
    end
    clkEn = 1; dIn = 32'hCAFEF00D; tick();
    dIn = '0;
    readBack(8'h20, 32'hCAFEF00D, "R3 R10 write after stall");

    // R10: frozen output holds while new read is offered
    clkEn = 0;
    drive(ACT, 1'b0, 4'h0, 8'h10);
    tick(); tick();
    chk("R10 frozen dOut", dOut, 32'hCAFEF00D);
    chk("R10 frozen dOutEn", {31'b0, dOutEn}, 32'd1);
    clkEn = 1;
    drive(DES, 1'b0, 4'h0, 8'h0); tick(); tick();

    // R9: asynchronous output enable
    readBack(8'h10, 32'h1111BBBB, "R9 setup");
    oeN = 1; #1;
    chk("R9 oeN high", {31'b0, dOutEn}, 32'd0);
    oeN = 0; #1;
    chk("R9 oeN low", {31'b0, dOutEn}, 32'd1);

    // R7: each chip select alone blocks a write
    writeWord(3'b110, 4'hF, 8'h20, 32'h11111111);
    readBack(8'h20, 32'hCAFEF00D, "R7 csN1 high");
    writeWord(3'b000, 4'hF, 8'h20, 32'h22222222);
    readBack(8'h20, 32'hCAFEF00D, "R7 cs2 low");
    writeWord(3'b011, 4'hF, 8'h20, 32'h33333333);
    readBack(8'h20, 32'hCAFEF00D, "R7 csN3 high");

    // R4: single upper lane
    writeWord(ACT, 4'h8, 8'h20, 32'h77665544);
    readBack(8'h20, 32'h77FEF00D, "R4 lane3 only");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule